// File: doc/BRIEF.md
# Bidirectional 8-bit Timer with Two Compare Channels

This block is an 8-bit counter driven by a selectable count enable. The enable can come from one of five internal prescaled tick inputs. It can also come from the rising or the falling edge of an external pin, once that pin has been synchronised. A further setting stops the count altogether. The counter runs in one of four modes. Two modes count up and wrap. The other two count up to a turning value and then back down to zero. In each pair, the wrap or turning value is either the all-ones value or the active value of compare channel A.

Two compare channels hold a software-written buffer and an active value. The active value is refreshed from the buffer only at a mode-dependent point in the count cycle, so a new compare value never takes effect partway through a cycle. When the counter equals a channel's active value on a counting tick, that channel's flag is set and its match output pulses for one clock. Three flags share one write-one-to-clear register: overflow, match A and match B. Each flag drives an interrupt request only while its mask bit is set. Software reaches everything through a single-cycle write port.

Top module: `cmp_timer8`

## Requirements
- R1: The count enable follows control bits [2:0]. 0 stops the counter. 1 to 5 select tick_i[0] to tick_i[4]. 6 selects a falling edge and 7 a rising edge of pin_i. The pin passes through two synchronising flops before edge detection, so an edge advances the counter on the third clock edge after the pin changes.
- R2: Mode 0 (control bits [4:3] = 00) counts up from 0x00 to 0xFF and wraps to 0x00. The overflow flag (flag bit 0) is set on the wrapping tick.
- R3: Mode 1 counts up to the active compare A value and then wraps to 0x00, setting the overflow flag. A counter above that value runs on to 0xFF, then wraps and sets the flag.
- R4: Modes 2 and 3 count up to the turning value (0xFF in mode 2, active compare A in mode 3), then down to 0x00, then up again. The overflow flag is set on the tick that turns the count upward at 0x00.
- R5: A write to a compare address changes only that channel's buffer. The buffer is copied to the active value on the wrapping tick at TOP in modes 0 and 1, and on the turning tick at 0x00 in modes 2 and 3.
- R6: On a counting tick where the counter equals a channel's active value, that channel's flag is set (bit 1 for A, bit 2 for B), and its match_o bit is high for exactly the following clock.
- R7: A counter write replaces the count and takes priority over a tick in the same cycle. It also suppresses the compare match on the next counting tick.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as a clear leaves the flag set.
- R9: irq_o bit k is high exactly when flag bit k and mask bit k are both set.
- R10: The write addresses are 0 for control, 1 for counter, 2 for compare A buffer, 3 for compare B buffer, 4 for mask (bits [2:0]) and 5 for flag clear (bits [2:0]).
- R11: After reset, the counter, both compare values, flags, mask and control are zero and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 5 | Prescaled count enables, one per internal source |
| pin_i | input | 1 | Asynchronous external count pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| cnt_o | output | 8 | Current counter value |
| cmp_a_o | output | 8 | Active compare A value |
| cmp_b_o | output | 8 | Active compare B value |
| flag_o | output | 3 | Flags: overflow, match A, match B |
| irq_o | output | 3 | Masked interrupt requests |
| match_o | output | 2 | One-clock compare match pulses, A and B |

## Verification
The assertions assume that pin_i may change at any time, with the synchroniser handling it. They also assume that the tick inputs and write strobes are sampled as ordinary synchronous inputs that are stable around the rising clock edge. The step checks in up/down modes assume that no counter write and no mode change happens in the checked cycle. The stimulus drives every input on the falling clock edge and toggles the pin a few clocks apart. It changes the mode only through ordinary control writes, and the reference model follows those writes cycle by cycle.

// File: rtl/cmp_timer8_pkg.sv
package cmp_timer8_pkg;
  localparam int NCMP   = 2;
  localparam int NFLAG  = NCMP + 1;
  localparam int CTRL_W = 5;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_COUNT = 3'd1;
  localparam logic [2:0] A_CMPA  = 3'd2;
  localparam logic [2:0] A_CMPB  = 3'd3;
  localparam logic [2:0] A_MASK  = 3'd4;
  localparam logic [2:0] A_FLAGS = 3'd5;

  localparam logic [2:0] SEL_STOP = 3'd0;
  localparam logic [2:0] SEL_FALL = 3'd6;
  localparam logic [2:0] SEL_RISE = 3'd7;

  localparam int FLAG_OVF = 0;

  typedef enum logic [1:0] {
    MODE_UP_MAX = 2'b00,
    MODE_UP_A   = 2'b01,
    MODE_UD_MAX = 2'b10,
    MODE_UD_A   = 2'b11
  } tmode_e;
endpackage

// File: rtl/cmp_timer8_clksel.sv
module cmp_timer8_clksel
  import cmp_timer8_pkg::*;
#(
  parameter int NTICK       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel_i,
  input  logic [NTICK-1:0] tick_i,
  input  logic             pin_i,
  output logic             tick_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;
  logic pin_now, pin_prev, pin_rise, pin_fall;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign pin_now  = sh_q[SYNC_STAGES-1];
  assign pin_prev = sh_q[SYNC_STAGES];
  assign pin_rise = pin_now & ~pin_prev;
  assign pin_fall = ~pin_now & pin_prev;

  always_comb begin
    tick_o = 1'b0;
    case (sel_i)
      SEL_STOP: tick_o = 1'b0;
      SEL_FALL: tick_o = pin_fall;
      SEL_RISE: tick_o = pin_rise;
      default: begin
        for (int k = 0; k < NTICK; k++) begin
          if (sel_i == 3'(k + 1)) tick_o = tick_i[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/cmp_timer8_counter.sv
module cmp_timer8_counter
  import cmp_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             upd_evt_o,
  output logic             cmp_en_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             blk_q, blk_d;
  logic             updown, at_top, at_max, at_bot;

  assign updown = mode_i[1];
  assign at_top = (cnt_q == top_i);
  assign at_max = (cnt_q == CNT_MAX);
  assign at_bot = (cnt_q == '0);

  always_comb begin
    cnt_d     = cnt_q;
    down_d    = down_q;
    blk_d     = blk_q;
    ovf_evt_o = 1'b0;
    upd_evt_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
      blk_d = 1'b1;
    end else if (tick_i) begin
      blk_d = 1'b0;
      if (!updown) begin
        cnt_d     = at_top ? '0 : cnt_q + CNT_ONE;
        ovf_evt_o = at_top | at_max;
        upd_evt_o = at_top;
      end else if (down_q) begin
        if (at_bot) begin
          down_d    = 1'b0;
          ovf_evt_o = 1'b1;
          upd_evt_o = 1'b1;
          cnt_d     = (top_i == '0) ? '0 : CNT_ONE;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end else if (cnt_q >= top_i) begin
        down_d = 1'b1;
        cnt_d  = at_bot ? '0 : cnt_q - CNT_ONE;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      blk_q  <= blk_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign cmp_en_o = tick_i & ~load_i & ~blk_q;
endmodule

// File: rtl/cmp_timer8_compare.sv
module cmp_timer8_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic             upd_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] act_o,
  output logic             match_evt_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] buf_q, buf_d, act_q, act_d;
  logic             pulse_q;

  assign match_evt_o = cmp_en_i & (cnt_i == act_q);

  always_comb begin
    buf_d = wr_i  ? wr_val_i : buf_q;
    act_d = upd_i ? buf_q    : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      act_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      act_q   <= act_d;
      pulse_q <= match_evt_o;
    end
  end

  assign act_o   = act_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/cmp_timer8_irq.sv
module cmp_timer8_irq #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] mask_i,
  output logic [NF-1:0] flag_o,
  output logic [NF-1:0] irq_o
);
  logic [NF-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = (flag_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & mask_i;
endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
  import cmp_timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int NTICK       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTICK-1:0] tick_i,
  input  logic             pin_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_a_o,
  output logic [CNT_W-1:0] cmp_b_o,
  output logic [NFLAG-1:0] flag_o,
  output logic [NFLAG-1:0] irq_o,
  output logic [NCMP-1:0]  match_o
);
  logic rst_meta, rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NFLAG-1:0]  mask_q, mask_d;
  logic              ctrl_we, mask_we, cnt_we, flag_we;
  logic [2:0]        clk_sel;
  logic [1:0]        mode;

  assign ctrl_we = wr_en_i && (wr_addr_i == A_CTRL);
  assign mask_we = wr_en_i && (wr_addr_i == A_MASK);
  assign cnt_we  = wr_en_i && (wr_addr_i == A_COUNT);
  assign flag_we = wr_en_i && (wr_addr_i == A_FLAGS);

  always_comb begin
    ctrl_d = ctrl_we ? wr_data_i[CTRL_W-1:0] : ctrl_q;
    mask_d = mask_we ? wr_data_i[NFLAG-1:0]  : mask_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
    end
  end

  assign clk_sel = ctrl_q[2:0];
  assign mode    = ctrl_q[4:3];

  logic tmr_tick;

  cmp_timer8_clksel #(.NTICK(NTICK), .SYNC_STAGES(SYNC_STAGES)) u_clksel (
    .clk    (clk),
    .rst_n  (rst_ns),
    .sel_i  (clk_sel),
    .tick_i (tick_i),
    .pin_i  (pin_i),
    .tick_o (tmr_tick)
  );

  logic [CNT_W-1:0] cmp_act [NCMP];
  logic [CNT_W-1:0] top_val;
  logic             ovf_evt, upd_evt, cmp_en;

  assign top_val = mode[0] ? cmp_act[0] : '1;

  cmp_timer8_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_ns),
    .tick_i     (tmr_tick),
    .mode_i     (mode),
    .top_i      (top_val),
    .load_i     (cnt_we),
    .load_val_i (wr_data_i),
    .cnt_o      (cnt_o),
    .ovf_evt_o  (ovf_evt),
    .upd_evt_o  (upd_evt),
    .cmp_en_o   (cmp_en)
  );

  logic [NCMP-1:0]  match_evt;
  logic [NFLAG-1:0] flag_set;

  generate
    for (genvar ch = 0; ch < NCMP; ch++) begin : g_cmp
      logic ch_wr;
      assign ch_wr = wr_en_i && (wr_addr_i == A_CMPA + 3'(ch));
      cmp_timer8_compare #(.CNT_W(CNT_W)) u_compare (
        .clk         (clk),
        .rst_n       (rst_ns),
        .wr_i        (ch_wr),
        .wr_val_i    (wr_data_i),
        .upd_i       (upd_evt),
        .cmp_en_i    (cmp_en),
        .cnt_i       (cnt_o),
        .act_o       (cmp_act[ch]),
        .match_evt_o (match_evt[ch]),
        .pulse_o     (match_o[ch])
      );
      assign flag_set[ch + 1] = match_evt[ch];
    end
  endgenerate

  assign flag_set[FLAG_OVF] = ovf_evt;

  cmp_timer8_irq #(.NF(NFLAG)) u_irq (
    .clk    (clk),
    .rst_n  (rst_ns),
    .set_i  (flag_set),
    .clr_i  (flag_we ? wr_data_i[NFLAG-1:0] : '0),
    .mask_i (mask_q),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );

  assign cmp_a_o = cmp_act[0];
  assign cmp_b_o = cmp_act[1];
endmodule

// File: rtl/cmp_timer8_chk.sv
module cmp_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             tmr_tick,
  input logic             cnt_we,
  input logic [2:0]       clk_sel,
  input logic [1:0]       mode,
  input logic [2:0]       mask_q,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cmp_a_o,
  input logic [2:0]       flag_o,
  input logic [2:0]       irq_o,
  input logic [1:0]       match_o,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i
);
  assert_stopped_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (clk_sel == 3'd0 && !cnt_we) |=> $stable(cnt_o));

  assert_wrap_max_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (tmr_tick && !cnt_we && mode == 2'b00 && cnt_o == '1) |=> (cnt_o == '0 && flag_o[0]));

  assert_wrap_a_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (tmr_tick && !cnt_we && mode == 2'b01 && cnt_o == cmp_a_o) |=> (cnt_o == '0 && flag_o[0]));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (tmr_tick && !cnt_we && mode[1] && cnt_o != '0 && cnt_o != '1) |=>
      (cnt_o == CNT_W'($past(cnt_o) + 1'b1) || cnt_o == CNT_W'($past(cnt_o) - 1'b1)));

  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(cmp_a_o) |-> $past(tmr_tick && !cnt_we));

  assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (match_o[0] |-> flag_o[1]) and (match_o[1] |-> flag_o[2]));

  assert_match_tick_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (|match_o) |-> $past(tmr_tick && !cnt_we));

  assert_load_nomatch_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    cnt_we |=> (match_o == 2'b00));

  assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(flag_o[0]) |-> $past(wr_en_i && wr_addr_i == 3'd5 && wr_data_i[0]));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    ((irq_o & ~flag_o) == 3'b000) && ((irq_o & ~mask_q) == 3'b000));
endmodule

bind cmp_timer8 cmp_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .tmr_tick  (tmr_tick),
  .cnt_we    (cnt_we),
  .clk_sel   (clk_sel),
  .mode      (mode),
  .mask_q    (mask_q),
  .cnt_o     (cnt_o),
  .cmp_a_o   (cmp_a_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .match_o   (match_o),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i)
);

// File: tb/cmp_timer8_tb.sv
module cmp_timer8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] tick_i = '0;
  logic       pin_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] cnt_o, cmp_a_o, cmp_b_o;
  logic [2:0] flag_o, irq_o;
  logic [1:0] match_o;

  always #4 clk = ~clk;

  cmp_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(pin_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cnt_o(cnt_o), .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o),
    .flag_o(flag_o), .irq_o(irq_o), .match_o(match_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  string scen = "R11";
  bit tick_rand = 1'b0;
  int pin_per = 0;
  int pin_cnt = 0;

  int m_cnt, m_down, m_blk, m_flag, m_mask, m_ctrl, m_match, m_s1, m_s2, m_s3;
  int m_act[2];
  int m_buf[2];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, updated at each rising edge from pre-edge values
  always @(posedge clk) begin : model
    int sel, mode, tt, ld, top, nc, nd, ov, up, me, clr;
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_blk = 0; m_flag = 0; m_mask = 0; m_ctrl = 0;
      m_match = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_act[0] = 0; m_act[1] = 0; m_buf[0] = 0; m_buf[1] = 0;
    end else begin
      sel  = m_ctrl % 8;
      mode = m_ctrl / 8;
      if (sel == 0) tt = 0;
      else if (sel == 6) tt = (m_s2 == 0 && m_s3 == 1) ? 1 : 0;
      else if (sel == 7) tt = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
      else tt = int'(tick_i[sel-1]);
      ld  = (wr_en_i && wr_addr_i == 3'd1) ? 1 : 0;
      top = (mode % 2 == 1) ? m_act[0] : 255;
      nc = m_cnt; nd = m_down; ov = 0; up = 0; me = 0;
      if (ld == 0 && tt == 1) begin
        if (mode < 2) begin
          if (m_cnt == top) begin nc = 0; ov = 1; up = 1; end
          else begin nc = (m_cnt + 1) % 256; ov = (m_cnt == 255) ? 1 : 0; end
        end else if (m_down == 1) begin
          if (m_cnt == 0) begin nd = 0; ov = 1; up = 1; nc = (top == 0) ? 0 : 1; end
          else nc = m_cnt - 1;
        end else if (m_cnt >= top) begin
          nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1;
        end else nc = m_cnt + 1;
        if (m_blk == 0) begin
          if (m_cnt == m_act[0]) me = me | 1;
          if (m_cnt == m_act[1]) me = me | 2;
        end
      end
      clr = (wr_en_i && wr_addr_i == 3'd5) ? int'(wr_data_i[2:0]) : 0;
      m_flag  = (m_flag & ~clr & 7) | (me * 2) | ov;
      m_match = me;
      if (ld == 1) begin m_blk = 1; nc = int'(wr_data_i); end
      else if (tt == 1) m_blk = 0;
      m_cnt = nc; m_down = nd;
      if (up == 1) begin m_act[0] = m_buf[0]; m_act[1] = m_buf[1]; end
      if (wr_en_i && wr_addr_i == 3'd2) m_buf[0] = int'(wr_data_i);
      if (wr_en_i && wr_addr_i == 3'd3) m_buf[1] = int'(wr_data_i);
      if (wr_en_i && wr_addr_i == 3'd0) m_ctrl = int'(wr_data_i[4:0]);
      if (wr_en_i && wr_addr_i == 3'd4) m_mask = int'(wr_data_i[2:0]);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(pin_i);
    end
  end

  // Per-cycle comparison, away from both clock edges
  always @(posedge clk) begin
    string creq;
    #2;
    if (rst_n) begin
      if (m_ctrl / 8 == 0) creq = "R2";
      else if (m_ctrl / 8 == 1) creq = "R3";
      else creq = "R4";
      check({creq, " ", scen}, "cnt_o", int'(cnt_o), m_cnt);
      check({"R5 R10 ", scen}, "cmp_a_o", int'(cmp_a_o), m_act[0]);
      check({"R5 R10 ", scen}, "cmp_b_o", int'(cmp_b_o), m_act[1]);
      check({"R6 R8 ", scen}, "flag_o", int'(flag_o), m_flag);
      check({"R9 ", scen}, "irq_o", int'(irq_o), m_flag & m_mask);
      check({"R6 ", scen}, "match_o", int'(match_o), m_match);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  always @(negedge clk) begin
    tick_i <= tick_rand ? 5'($urandom) : 5'h1F;
    if (pin_per > 0) begin
      pin_cnt++;
      if (pin_cnt >= pin_per) begin
        pin_cnt = 0;
        pin_i <= ~pin_i;
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_addr_i = 3'(a);
    wr_data_i = 8'(d);
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  task automatic run(input int n, input int clr_div);
    repeat (n) begin
      if (clr_div > 0 && ($urandom % clr_div) == 0) wr(5, int'($urandom % 8));
      else @(negedge clk);
    end
  endtask

  initial begin
    int hold;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "reset cnt_o", int'(cnt_o), 0);
    check("R11", "reset flag_o", int'(flag_o), 0);
    check("R11", "reset cmp_a_o", int'(cmp_a_o), 0);
    check("R11", "reset irq_o", int'(irq_o), 0);

    scen = "R10";
    wr(4, 7);
    wr(2, 8'h30);
    wr(3, 8'hC0);
    wr(0, 5'b00_001);
    run(700, 4);
    check("R5", "compare A after update", int'(cmp_a_o), 8'h30);

    scen = "R1";
    wr(0, 5'b00_000);
    hold = int'(cnt_o);
    run(40, 0);
    check("R1", "stopped counter", int'(cnt_o), hold);

    scen = "R7";
    wr(1, 8'h30);
    wr(5, 7);
    wr(0, 5'b00_001);
    run(3, 0);
    check("R7", "match A suppressed after load", int'(flag_o[1]), 0);
    check("R7", "count after load", int'(cnt_o) >= 8'h31 ? 1 : 0, 1);

    scen = "R1";
    tick_rand = 1'b1;
    for (int s = 1; s <= 5; s++) begin
      wr(0, s);
      run(300, 6);
    end

    scen = "R3";
    tick_rand = 1'b0;
    wr(2, 8'h40);
    wr(0, 5'b01_001);
    run(600, 5);
    wr(2, 8'h18);
    run(700, 5);

    scen = "R4";
    wr(0, 5'b10_001);
    run(1200, 8);
    wr(2, 8'h50);
    wr(0, 5'b11_001);
    run(700, 8);
    wr(2, 8'h30);
    wr(3, 8'h10);
    run(700, 8);

    scen = "R1";
    pin_per = 3;
    wr(0, 5'b00_111);
    run(400, 6);
    wr(0, 5'b00_110);
    run(400, 6);
    pin_per = 0;

    scen = "R9";
    wr(0, 5'b00_001);
    wr(4, 3'b010);
    run(400, 10);
    check("R9", "masked irq bits", int'(irq_o & 3'b101), 0);
    wr(4, 0);
    run(50, 0);
    check("R9", "all masked", int'(irq_o), 0);

    scen = "R8";
    wr(4, 7);
    run(600, 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule